// File: doc/BRIEF.md
# SPI Transmit/Receive Stream Feeder

This block runs on the parallel-side clock next to an SPI master that signals, a fixed number of cycles ahead, when it wants its next transmit word. A start command gives a transmit base address, a receive base address and a word count. The block reads transmit words from a synchronous RAM with a registered read port and hands each word to the master with a one-cycle write strobe. It also writes every received word into a receive store.

The first word of a run is fetched on the block's own initiative, because an idle master only starts when it is given a word. Each later word is fetched on the rising edge of the master's request line. The RAM address is already waiting in a counter, so the read enable goes out in the same cycle the request is seen. The write strobe follows `RAM_LAT + 1` cycles later. Received words arrive with a valid strobe that lasts more than one cycle. The block writes on the rising edge of that strobe only. A one-cycle done pulse marks the last receive write of the run.

Top module: `spi_feed_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `done_o`, `mst_wren_o`, `ram_ren_o` and `rx_we_o` are all 0.
- R2: A start with a nonzero count while idle sets `busy_o` in the next cycle. In that same cycle the block raises `ram_ren_o` with `ram_raddr_o` equal to the transmit base, with no request from the master.
- R3: While busy, a rising edge on `mst_req_i` raises `ram_ren_o` in the same cycle at the next transmit address. `RAM_LAT + 1` cycles later, `mst_wren_o` is 1 for exactly one cycle, with `mst_wdata_o` equal to the RAM word at that address.
- R4: `mst_wdata_o` changes only in a cycle where `mst_wren_o` is 1, and it holds its value between strobes.
- R5: After a word has been fetched, request edges cause no RAM read until `mst_ack_i` has been seen.
- R6: Once `count` words have been fetched, further request edges cause no RAM read and no write strobe.
- R7: Each rising edge of `mst_rvalid_i` while busy gives exactly one `rx_we_o` pulse in the next cycle, however long the valid stays high. That pulse carries the `mst_rdata_i` of the edge cycle, at receive base plus the number of words stored before it.
- R8: `done_o` is a one-cycle pulse that coincides with the `count`-th receive write. `busy_o` is 0 in that same cycle.
- R9: A start while busy, or a start with a count of 0, is ignored. It does not alter the busy state or the addresses in use.
- R10: While idle, request and receive-valid edges cause no RAM read and no receive write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Start command strobe |
| cmd_tx_base_i | input | AW | First transmit RAM address |
| cmd_rx_base_i | input | AW | First receive store address |
| cmd_count_i | input | CW | Words to send and receive |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mst_req_i | input | 1 | Master lookahead data request |
| mst_wren_o | output | 1 | Write strobe to the master |
| mst_wdata_o | output | DW | Transmit word to the master |
| mst_ack_i | input | 1 | Master write acknowledge |
| mst_rdata_i | input | DW | Received word from the master |
| mst_rvalid_i | input | 1 | Received word valid (multi-cycle) |
| ram_ren_o | output | 1 | Transmit RAM read enable |
| ram_raddr_o | output | AW | Transmit RAM read address |
| ram_rdata_i | input | DW | Transmit RAM read data |
| rx_we_o | output | 1 | Receive store write enable |
| rx_waddr_o | output | AW | Receive store write address |
| rx_wdata_o | output | DW | Receive store write data |

## Verification
The hardest cases to reach are request edges that land where they must be refused. One kind arrives while a fetched word is still waiting for its acknowledge. The other is a trailing request after the final word has already been fetched. The bench plays the master cycle by cycle, so it can place a request pulse in the exact cycle the write strobe appears, before the acknowledge. It can also place one after the last fetch. Receive-valid is held for two and for three cycles to show that one write still results.

// File: rtl/spi_feed_pkg.sv
package spi_feed_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;

endpackage

// File: rtl/spi_feed_rise.sv
module spi_feed_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/spi_feed_tx.sv
module spi_feed_tx #(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int CW      = 8,
  parameter int RAM_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          run_i,
  input  logic          req_rise_i,
  input  logic          ack_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          ram_ren_o,
  output logic [AW-1:0] ram_raddr_o,
  output logic          wren_o,
  output logic [DW-1:0] wdata_o
);

  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0]      addr_q, addr_d;
  logic [CW-1:0]      left_q, left_d;
  logic               kick_q, kick_d;
  logic               pend_q, pend_d;
  logic [RAM_LAT-1:0] vld_q, vld_d;
  logic               wren_q, wren_d;
  logic [DW-1:0]      wdata_q, wdata_d;
  logic               fetch;
  logic               pop;

  assign fetch = run_i & (left_q != '0) & ~pend_q & (kick_q | req_rise_i);
  assign pop   = vld_q[RAM_LAT-1];

  generate
    if (RAM_LAT == 1) begin : g_lat1
      assign vld_d = fetch;
    end else begin : g_latn
      assign vld_d = {vld_q[RAM_LAT-2:0], fetch};
    end
  endgenerate

  always_comb begin
    addr_d  = addr_q;
    left_d  = left_q;
    kick_d  = kick_q;
    pend_d  = pend_q;
    wren_d  = pop;
    wdata_d = wdata_q;
    if (load_i) begin
      addr_d = base_i;
      left_d = count_i;
      kick_d = 1'b1;
      pend_d = 1'b0;
    end else if (fetch) begin
      addr_d = addr_q + ONE_A;
      left_d = left_q - ONE_C;
      kick_d = 1'b0;
      pend_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end
    if (pop) wdata_d = ram_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      kick_q  <= 1'b0;
      pend_q  <= 1'b0;
      vld_q   <= '0;
      wren_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      left_q  <= left_d;
      kick_q  <= kick_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      wren_q  <= wren_d;
      wdata_q <= wdata_d;
    end
  end

  assign ram_ren_o   = fetch;
  assign ram_raddr_o = addr_q;
  assign wren_o      = wren_q;
  assign wdata_o     = wdata_q;

  // R3: the strobe to the master lasts a single cycle
  a_r3_wren_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    wren_o |=> !wren_o);

  // R4: transmit data only moves together with a strobe
  a_r4_wdata_held : assert property (@(posedge clk) disable iff (!rst_n)
    !wren_o |-> $stable(wdata_o));

  // R5: a word awaiting acknowledge blocks the next read
  a_r5_no_refetch : assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i && !load_i) |=> !ram_ren_o);

  // R6: an exhausted count blocks any further read
  a_r6_no_overrun : assert property (@(posedge clk) disable iff (!rst_n)
    (left_q == '0 && !load_i) |=> !ram_ren_o);

  // R10: reads only happen during a run
  a_r10_read_in_run : assert property (@(posedge clk) disable iff (!rst_n)
    ram_ren_o |-> run_i);

endmodule

// File: rtl/spi_feed_rx.sv
module spi_feed_rx #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          run_i,
  input  logic          vld_rise_i,
  input  logic [DW-1:0] rdata_i,
  output logic          last_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);

  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] left_q, left_d;
  logic          we_q;
  logic [AW-1:0] waddr_q, waddr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          store;

  assign store  = run_i & vld_rise_i & (left_q != '0);
  assign last_o = store & (left_q == ONE_C);

  always_comb begin
    addr_d  = addr_q;
    left_d  = left_q;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    if (load_i) begin
      addr_d = base_i;
      left_d = count_i;
    end else if (store) begin
      addr_d  = addr_q + ONE_A;
      left_d  = left_q - ONE_C;
      waddr_d = addr_q;
      wdata_d = rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      left_q  <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      left_q  <= left_d;
      we_q    <= store;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;

  // R7: one write per valid edge, never two in a row
  a_r7_we_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> !we_o);

  // R7: a write always follows an observed valid edge
  a_r7_we_after_edge : assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> $past(vld_rise_i));

endmodule

// File: rtl/spi_feed_seq.sv
module spi_feed_seq
  import spi_feed_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int CW      = 8,
  parameter int RAM_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start_i,
  input  logic [AW-1:0] cmd_tx_base_i,
  input  logic [AW-1:0] cmd_rx_base_i,
  input  logic [CW-1:0] cmd_count_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic          mst_req_i,
  output logic          mst_wren_o,
  output logic [DW-1:0] mst_wdata_o,
  input  logic          mst_ack_i,
  input  logic [DW-1:0] mst_rdata_i,
  input  logic          mst_rvalid_i,
  output logic          ram_ren_o,
  output logic [AW-1:0] ram_raddr_o,
  input  logic [DW-1:0] ram_rdata_i,
  output logic          rx_we_o,
  output logic [AW-1:0] rx_waddr_o,
  output logic [DW-1:0] rx_wdata_o
);

  run_st_e st_q, st_d;
  logic    done_q;
  logic    load;
  logic    run;
  logic    req_rise;
  logic    vld_rise;
  logic    rx_last;

  assign run  = (st_q == ST_RUN);
  assign load = cmd_start_i & ~run & (cmd_count_i != '0);

  always_comb begin
    st_d = st_q;
    if (load)                st_d = ST_RUN;
    else if (run && rx_last) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= rx_last;
    end
  end

  spi_feed_rise i_req_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (mst_req_i),
    .rise_o (req_rise)
  );

  spi_feed_rise i_vld_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (mst_rvalid_i),
    .rise_o (vld_rise)
  );

  spi_feed_tx #(.DW(DW), .AW(AW), .CW(CW), .RAM_LAT(RAM_LAT)) i_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .base_i      (cmd_tx_base_i),
    .count_i     (cmd_count_i),
    .run_i       (run),
    .req_rise_i  (req_rise),
    .ack_i       (mst_ack_i),
    .ram_rdata_i (ram_rdata_i),
    .ram_ren_o   (ram_ren_o),
    .ram_raddr_o (ram_raddr_o),
    .wren_o      (mst_wren_o),
    .wdata_o     (mst_wdata_o)
  );

  spi_feed_rx #(.DW(DW), .AW(AW), .CW(CW)) i_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .base_i     (cmd_rx_base_i),
    .count_i    (cmd_count_i),
    .run_i      (run),
    .vld_rise_i (vld_rise),
    .rdata_i    (mst_rdata_i),
    .last_o     (rx_last),
    .we_o       (rx_we_o),
    .waddr_o    (rx_waddr_o),
    .wdata_o    (rx_wdata_o)
  );

  assign busy_o = run;
  assign done_o = done_q;

  // R8: the end pulse lasts one cycle and finds the block idle
  a_r8_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && rx_we_o));
  a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a start during a run leaves the run in place
  a_r9_start_ignored : assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_start_i && !rx_last) |=> busy_o);

  // R10: receive writes only happen during or at the end of a run
  a_r10_rx_in_run : assert property (@(posedge clk) disable iff (!rst_n)
    rx_we_o |-> ($past(busy_o)));

endmodule

// File: tb/test_spi_feed_seq.sv
module test_spi_feed_seq;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] tx_base = '0;
  logic [AW-1:0] rx_base = '0;
  logic [CW-1:0] count = '0;
  logic          busy, done;
  logic          req = 1'b0;
  logic          wren;
  logic [DW-1:0] wdata;
  logic          ack = 1'b0;
  logic [DW-1:0] m_rdata = '0;
  logic          rv = 1'b0;
  logic          ren;
  logic [AW-1:0] raddr;
  logic [DW-1:0] ram_q = '0;
  logic          rx_we;
  logic [AW-1:0] rx_waddr;
  logic [DW-1:0] rx_wdata;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction

  always @(posedge clk) if (ren) ram_q <= pat(raddr);

  spi_feed_seq #(.DW(DW), .AW(AW), .CW(CW), .RAM_LAT(1)) i_spi_feed_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start_i   (start),
    .cmd_tx_base_i (tx_base),
    .cmd_rx_base_i (rx_base),
    .cmd_count_i   (count),
    .busy_o        (busy),
    .done_o        (done),
    .mst_req_i     (req),
    .mst_wren_o    (wren),
    .mst_wdata_o   (wdata),
    .mst_ack_i     (ack),
    .mst_rdata_i   (m_rdata),
    .mst_rvalid_i  (rv),
    .ram_ren_o     (ren),
    .ram_raddr_o   (raddr),
    .ram_rdata_i   (ram_q),
    .rx_we_o       (rx_we),
    .rx_waddr_o    (rx_waddr),
    .rx_wdata_o    (rx_wdata)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  // R1
  task automatic t_reset;
    rst_n = 1'b0;
    tick; tick;
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "wren in reset", 32'(wren), 0);
    chk("R1", "ren in reset", 32'(ren), 0);
    rst_n = 1'b1;
    tick;
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "rx_we after reset", 32'(rx_we), 0);
    chk("R1", "busy after reset", 32'(busy), 0);
  endtask

  // R10
  task automatic t_idle_ignore;
    req = 1'b1; #1;
    chk("R10", "ren idle req", 32'(ren), 0);
    tick; req = 1'b0; rv = 1'b1; m_rdata = 16'hDEAD;
    tick;
    chk("R10", "rx_we idle", 32'(rx_we), 0);
    rv = 1'b0;
    tick;
    chk("R10", "rx_we idle later", 32'(rx_we), 0);
    chk("R10", "busy idle", 32'(busy), 0);
  endtask

  // Completes a fetch whose read enable was seen this cycle (R3, R4, R5)
  task automatic finish_word(input logic [AW-1:0] a);
    tick; #1;
    chk("R3", "ren drops", 32'(ren), 0);
    tick;
    chk("R3", "wren strobe", 32'(wren), 1);
    chk("R3", "wdata word", 32'(wdata), 32'(pat(a)));
    req = 1'b1; #1;
    chk("R5", "ren while pending", 32'(ren), 0);
    tick;
    chk("R3", "wren single", 32'(wren), 0);
    chk("R4", "wdata held", 32'(wdata), 32'(pat(a)));
    req = 1'b0; ack = 1'b1;
    tick;
    ack = 1'b0;
    tick;
    chk("R4", "wdata still held", 32'(wdata), 32'(pat(a)));
  endtask

  // R2
  task automatic t_start(input logic [AW-1:0] tb_, input logic [AW-1:0] rb_,
                         input logic [CW-1:0] n);
    tx_base = tb_; rx_base = rb_; count = n; start = 1'b1;
    tick;
    start = 1'b0; #1;
    chk("R2", "busy set", 32'(busy), 1);
    chk("R2", "auto ren", 32'(ren), 1);
    chk("R2", "auto raddr", 32'(raddr), 32'(tb_));
    finish_word(tb_);
  endtask

  // R3
  task automatic t_fetch(input logic [AW-1:0] a);
    req = 1'b1; #1;
    chk("R3", "ren on req", 32'(ren), 1);
    chk("R3", "raddr on req", 32'(raddr), 32'(a));
    finish_word(a);
  endtask

  // R7, R8
  task automatic t_rx(input logic [DW-1:0] d, input int len,
                      input logic [AW-1:0] a, input bit last);
    rv = 1'b1; m_rdata = d;
    tick;
    chk("R7", "rx_we", 32'(rx_we), 1);
    chk("R7", "rx_waddr", 32'(rx_waddr), 32'(a));
    chk("R7", "rx_wdata", 32'(rx_wdata), 32'(d));
    chk("R8", "done at write", 32'(done), 32'(last));
    if (last) chk("R8", "busy cleared", 32'(busy), 0);
    for (int i = 1; i < len; i++) begin
      m_rdata = ~d;
      tick;
      chk("R7", "no second write", 32'(rx_we), 0);
    end
    rv = 1'b0;
    tick;
    chk("R7", "rx_we low", 32'(rx_we), 0);
    chk("R8", "done single", 32'(done), 0);
    chk("R7", "rx_wdata kept", 32'(rx_wdata), 32'(d));
  endtask

  // R9
  task automatic t_start_busy;
    tx_base = 8'h80; count = 8'd5; start = 1'b1;
    tick;
    start = 1'b0; #1;
    chk("R9", "no kick when busy", 32'(ren), 0);
    chk("R9", "still busy", 32'(busy), 1);
  endtask

  // R9
  task automatic t_zero_count;
    count = '0; tx_base = 8'h33; start = 1'b1;
    tick;
    start = 1'b0; #1;
    chk("R9", "zero count busy", 32'(busy), 0);
    chk("R9", "zero count ren", 32'(ren), 0);
    tick;
  endtask

  // R6
  task automatic t_past_end;
    req = 1'b1; #1;
    chk("R6", "ren past end", 32'(ren), 0);
    tick; req = 1'b0;
    tick;
    chk("R6", "no wren past end", 32'(wren), 0);
    tick;
    chk("R6", "no wren later", 32'(wren), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_idle_ignore;
    t_start(8'h10, 8'h40, 8'd3);
    t_start_busy;
    t_fetch(8'h11);
    t_rx(16'h1234, 2, 8'h40, 1'b0);
    t_fetch(8'h12);
    t_rx(16'hBEEF, 3, 8'h41, 1'b0);
    t_past_end;
    t_rx(16'h0F0F, 2, 8'h42, 1'b1);
    t_idle_ignore;
    t_zero_count;
    t_start(8'hFE, 8'h00, 8'd2);
    t_rx(16'hA001, 2, 8'h00, 1'b0);
    t_fetch(8'hFF);
    t_past_end;
    t_rx(16'hA002, 2, 8'h01, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule